// File: doc/BRIEF.md
# Frame Buffer DMA Address Sequencer

This block produces the read-burst addresses a display controller needs to fetch a colour palette and then frame pixel data from memory. A start pulse begins a load in one of three modes: palette followed by pixel data, palette alone, or pixel data alone. Each request carries a word address and a length. The length comes from a programmable burst-size code. The last burst before an end address is shortened so that it stops exactly on that address. Requests follow a plain request/acknowledge rule: a request and its fields stay unchanged until the memory side acknowledges it.

Pixel data is fetched between an inclusive base and ceiling word address. Two such pairs exist. When dual-buffer operation is on, fetching alternates between pair 0 and pair 1 on every frame. When it is off, only pair 0 is used. Completion events and fault conditions set sticky status flags that software clears by writing 1 to them. A single interrupt line combines the flags that have been enabled. An underflow flag records any cycle in which the downstream pixel FIFO is empty during active display while pixel data is being fetched.

Top module: `fbd_dma_seq`

## Requirements
- R1: A start pulse selects the load by `load_mode`. Code 0 fetches the palette, then pixel data from pair 0. Code 1 fetches the palette and then goes idle. Code 2 fetches pixel data from pair 0. Code 3 is ignored and leaves the block as it was.
- R2: The burst length in words is 1, 2, 4, 8 or 16 for `burst_code` 0, 1, 2, 3 or 4. Codes 5 to 7 give single-word bursts.
- R3: The ceiling address is inclusive. A burst never reaches past the current end address. The final burst of a range is shortened to end exactly on it, and each non-final burst advances the address by its length.
- R4: After the burst that reaches the ceiling, fetching restarts at the base of the next pair. That is the other pair when `dual_en` is 1, and pair 0 otherwise.
- R5: The palette spans 8 words (32 bytes, 4-bit pixels) when `pal_8bit` is 0 and 128 words (512 bytes, 8-bit pixels) when it is 1, starting at `pal_base`.
- R6: The status bits are set as follows. Bit 6 is set when the palette fetch completes. Bit 8 is set when a frame from pair 0 completes, and bit 9 when a frame from pair 1 completes.
- R7: Status bit 5 (underflow) is set after any cycle in which pixel data is being fetched, `active_disp` is 1 and `fifo_empty` is 1. It is not set in any other case.
- R8: Status bit 2 (sync lost) is set after any cycle with `sync_err` high.
- R9: A cycle with `clr_wr` high clears every status bit whose `clr_mask` bit is 1. A bit that is set in that same cycle stays set.
- R10: `irq` is high whenever an enabled status bit is set. `ie_eof` enables bits 8 and 9, `ie_unf` enables bit 5 and `ie_pl` enables bit 6. Bit 2 never raises `irq`.
- R11: While `req` is high and `ack` is low, `req` stays high and `req_addr` and `req_len` hold their values.
- R12: After reset, `req`, `stat` and `irq` are all 0. A `stop` pulse drops `req` in the next cycle, and `stop` takes priority over `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load in the selected mode |
| stop | input | 1 | Abandon fetching and go idle |
| load_mode | input | 2 | Load sequence selector |
| burst_code | input | 3 | Burst size code |
| dual_en | input | 1 | Alternate between the two buffer pairs |
| pal_8bit | input | 1 | Palette size select (0: 8 words, 1: 128 words) |
| pal_base | input | AW | Palette start word address |
| base0 | input | AW | Pair 0 base word address |
| ceil0 | input | AW | Pair 0 inclusive ceiling word address |
| base1 | input | AW | Pair 1 base word address |
| ceil1 | input | AW | Pair 1 inclusive ceiling word address |
| req | output | 1 | Burst request valid |
| req_addr | output | AW | Burst start word address |
| req_len | output | 5 | Burst length in words |
| ack | input | 1 | Memory side accepts the current burst |
| active_disp | input | 1 | Display is in its active region |
| fifo_empty | input | 1 | Downstream pixel FIFO is empty |
| sync_err | input | 1 | Downstream synchronisation error event |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 10 | Status bits to clear |
| ie_eof | input | 1 | Enable end-of-frame interrupts |
| ie_unf | input | 1 | Enable underflow interrupt |
| ie_pl | input | 1 | Enable palette-done interrupt |
| stat | output | 10 | Sticky status flags |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the boundary bursts. One is a shortened final burst that lands on the ceiling. The other is the handover from that burst to the base of the other pair, and both must coincide with an acknowledge pattern that stalls at awkward moments. The stimulus uses small range sizes that do not divide evenly by the burst size, together with random acknowledge gaps. A transaction-level model checks every accepted burst, so each range end and pair switch is compared as it happens. Directed runs cover palette-then-data chaining, the shortened burst, the ignored mode, underflow during fetching against underflow while idle, and a set and a clear in the same cycle.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAL  = 2'd1,
    ST_DATA = 2'd2
  } fbd_state_e;

  localparam logic [1:0] MODE_BOTH = 2'd0;
  localparam logic [1:0] MODE_PAL  = 2'd1;
  localparam logic [1:0] MODE_DATA = 2'd2;

  localparam int STAT_W    = 10;
  localparam int SB_SYNC   = 2;
  localparam int SB_UNF    = 5;
  localparam int SB_PLDONE = 6;
  localparam int SB_EOF0   = 8;
  localparam int SB_EOF1   = 9;

  localparam int LEN_W = 5;

  // Burst size code to words; unlisted codes fall back to one word.
  function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
    case (code)
      3'd0:    burst_words = 5'd1;
      3'd1:    burst_words = 5'd2;
      3'd2:    burst_words = 5'd4;
      3'd3:    burst_words = 5'd8;
      3'd4:    burst_words = 5'd16;
      default: burst_words = 5'd1;
    endcase
  endfunction

  // Palette length in 32-bit words: 32 bytes or 512 bytes.
  function automatic logic [7:0] pal_words(input logic pal8);
    pal_words = pal8 ? 8'd128 : 8'd8;
  endfunction

endpackage

// File: rtl/fbd_addr_gen.sv
module fbd_addr_gen
  import fbd_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [1:0]       load_mode,
  input  logic [2:0]       burst_code,
  input  logic             dual_en,
  input  logic             pal_8bit,
  input  logic [AW-1:0]    pal_base,
  input  logic [AW-1:0]    base0,
  input  logic [AW-1:0]    ceil0,
  input  logic [AW-1:0]    base1,
  input  logic [AW-1:0]    ceil1,
  input  logic             ack,
  output logic             req,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  output fbd_state_e       state,
  output logic             cur_pair,
  output logic             pal_done_evt,
  output logic [1:0]       eof_evt
);

  localparam int RW = AW + 1;

  fbd_state_e      state_q;
  logic [AW-1:0]   addr_q;
  logic            pair_q;
  logic [AW-1:0]   base_a [2];
  logic [AW-1:0]   ceil_a [2];
  logic [AW-1:0]   end_addr;
  logic [RW-1:0]   remain;
  logic [RW-1:0]   bw_ext;
  logic [LEN_W-1:0] bw;
  logic            last;
  logic            xfer;
  logic            quiet;
  logic            nxt_pair;

  assign base_a[0] = base0;
  assign base_a[1] = base1;
  assign ceil_a[0] = ceil0;
  assign ceil_a[1] = ceil1;

  assign bw       = burst_words(burst_code);
  assign end_addr = (state_q == ST_PAL)
                    ? pal_base + AW'(pal_words(pal_8bit)) - AW'(1)
                    : ceil_a[pair_q];
  assign remain   = {1'b0, end_addr} - {1'b0, addr_q} + RW'(1);
  assign bw_ext   = RW'(bw);
  assign last     = (remain <= bw_ext);
  assign req_len  = last ? remain[LEN_W-1:0] : bw;

  assign req      = (state_q != ST_IDLE);
  assign req_addr = addr_q;
  assign xfer     = req & ack;
  assign quiet    = ~stop & ~start;
  assign nxt_pair = dual_en ? ~pair_q : 1'b0;

  assign pal_done_evt = xfer & last & quiet & (state_q == ST_PAL);

  for (genvar p = 0; p < 2; p++) begin : g_eof
    assign eof_evt[p] = xfer & last & quiet & (state_q == ST_DATA) &
                        (pair_q == 1'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pair_q  <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      case (load_mode)
        MODE_BOTH, MODE_PAL: begin
          state_q <= ST_PAL;
          addr_q  <= pal_base;
          pair_q  <= 1'b0;
        end
        MODE_DATA: begin
          state_q <= ST_DATA;
          addr_q  <= base0;
          pair_q  <= 1'b0;
        end
        default: ;
      endcase
    end else if (xfer) begin
      if (!last) begin
        addr_q <= addr_q + AW'(req_len);
      end else if (state_q == ST_PAL) begin
        if (load_mode == MODE_BOTH) begin
          state_q <= ST_DATA;
          addr_q  <= base0;
          pair_q  <= 1'b0;
        end else begin
          state_q <= ST_IDLE;
        end
      end else begin
        pair_q <= nxt_pair;
        addr_q <= base_a[nxt_pair];
      end
    end
  end

  assign state    = state_q;
  assign cur_pair = pair_q;

endmodule

// File: rtl/fbd_status.sv
module fbd_status
  import fbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              ie_eof,
  input  logic              ie_unf,
  input  logic              ie_pl,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_mask;
  logic [STAT_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_comb begin
    en_mask            = '0;
    en_mask[SB_EOF0]   = ie_eof;
    en_mask[SB_EOF1]   = ie_eof;
    en_mask[SB_UNF]    = ie_unf;
    en_mask[SB_PLDONE] = ie_pl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_eff) | set_vec;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & en_mask);

endmodule

// File: rtl/fbd_dma_seq.sv
module fbd_dma_seq
  import fbd_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [1:0]    load_mode,
  input  logic [2:0]    burst_code,
  input  logic          dual_en,
  input  logic          pal_8bit,
  input  logic [AW-1:0] pal_base,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] ceil0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] ceil1,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic [4:0]    req_len,
  input  logic          ack,
  input  logic          active_disp,
  input  logic          fifo_empty,
  input  logic          sync_err,
  input  logic          clr_wr,
  input  logic [9:0]    clr_mask,
  input  logic          ie_eof,
  input  logic          ie_unf,
  input  logic          ie_pl,
  output logic [9:0]    stat,
  output logic          irq
);

  fbd_state_e        state_w;
  logic              pair_w;
  logic              pal_done_w;
  logic [1:0]        eof_w;
  logic              unf_w;
  logic [STAT_W-1:0] set_w;

  fbd_addr_gen #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .load_mode    (load_mode),
    .burst_code   (burst_code),
    .dual_en      (dual_en),
    .pal_8bit     (pal_8bit),
    .pal_base     (pal_base),
    .base0        (base0),
    .ceil0        (ceil0),
    .base1        (base1),
    .ceil1        (ceil1),
    .ack          (ack),
    .req          (req),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .state        (state_w),
    .cur_pair     (pair_w),
    .pal_done_evt (pal_done_w),
    .eof_evt      (eof_w)
  );

  assign unf_w = (state_w == ST_DATA) & active_disp & fifo_empty;

  always_comb begin
    set_w            = '0;
    set_w[SB_SYNC]   = sync_err;
    set_w[SB_UNF]    = unf_w;
    set_w[SB_PLDONE] = pal_done_w;
    set_w[SB_EOF0]   = eof_w[0];
    set_w[SB_EOF1]   = eof_w[1];
  end

  fbd_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_w),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .ie_eof   (ie_eof),
    .ie_unf   (ie_unf),
    .ie_pl    (ie_pl),
    .stat     (stat),
    .irq      (irq)
  );

endmodule

// File: rtl/fbd_chk.sv
module fbd_chk
  import fbd_pkg::*;
#(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic [2:0]    burst_code,
  input logic [AW-1:0] ceil0,
  input logic [AW-1:0] ceil1,
  input logic          req,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    req_len,
  input logic          ack,
  input logic          active_disp,
  input logic          fifo_empty,
  input logic          clr_wr,
  input logic [9:0]    clr_mask,
  input logic [9:0]    stat,
  input fbd_state_e    state_w,
  input logic          pair_w,
  input logic          pal_done_w,
  input logic [1:0]    eof_w
);

  logic [AW:0] last_word;
  logic [AW:0] cur_ceil;

  assign last_word = {1'b0, req_addr} + (AW+1)'(req_len) - (AW+1)'(1);
  assign cur_ceil  = {1'b0, (pair_w ? ceil1 : ceil0)};

  // R2
  len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_len != 5'd0) && (req_len <= burst_words(burst_code)));

  // R3
  no_pass_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && state_w == ST_DATA) |-> (last_word <= cur_ceil));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !start && !stop) |=> (req && $stable(req_addr) && $stable(req_len)));

  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eof_w, pal_done_w}));

  // R7
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_DATA && active_disp && fifo_empty) |=> stat[SB_UNF]);

  // R9
  eof0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[SB_EOF0] && !eof_w[0]) |=> !stat[SB_EOF0]);

  // R12
  stop_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !req);

endmodule

bind fbd_dma_seq fbd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stop        (stop),
  .burst_code  (burst_code),
  .ceil0       (ceil0),
  .ceil1       (ceil1),
  .req         (req),
  .req_addr    (req_addr),
  .req_len     (req_len),
  .ack         (ack),
  .active_disp (active_disp),
  .fifo_empty  (fifo_empty),
  .clr_wr      (clr_wr),
  .clr_mask    (clr_mask),
  .stat        (stat),
  .state_w     (state_w),
  .pair_w      (pair_w),
  .pal_done_w  (pal_done_w),
  .eof_w       (eof_w)
);

// File: tb/tb_fbd_dma_seq.sv
module tb_fbd_dma_seq;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, stop;
  logic [1:0]    load_mode;
  logic [2:0]    burst_code;
  logic          dual_en, pal_8bit;
  logic [AW-1:0] pal_base, base0, ceil0, base1, ceil1;
  logic          req;
  logic [AW-1:0] req_addr;
  logic [4:0]    req_len;
  logic          ack;
  logic          active_disp, fifo_empty, sync_err;
  logic          clr_wr;
  logic [9:0]    clr_mask;
  logic          ie_eof, ie_unf, ie_pl;
  logic [9:0]    stat;
  logic          irq;

  fbd_dma_seq #(.AW(AW)) dut (.*);

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // transaction model: 0 idle, 1 palette, 2 data
  int m_state, m_addr, m_pair;
  bit m_pl, m_e0, m_e1;

  function automatic int bw_of(int code);
    if (code <= 4) return 1 << code;
    return 1;
  endfunction

  function automatic int m_end();
    if (m_state == 1) return int'(pal_base) + (pal_8bit ? 128 : 8) - 1;
    return m_pair ? int'(ceil1) : int'(ceil0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_start();
    case (load_mode)
      2'd0, 2'd1: begin m_state = 1; m_addr = int'(pal_base); m_pair = 0; end
      2'd2:       begin m_state = 2; m_addr = int'(base0); m_pair = 0; end
      default: ;
    endcase
  endtask

  task automatic do_start();
    @(negedge clk);
    ack = 0; stop = 0; clr_wr = 0;
    start = 1;
    model_start();
  endtask

  task automatic do_stop();
    @(negedge clk);
    ack = 0; start = 0;
    stop = 1;
    m_state = 0;
  endtask

  // run cycles; accept bursts at pct percent and compare to the model
  task automatic run(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 0; stop = 0; clr_wr = 0; sync_err = 0;
      if ((m_state != 0) != req) begin
        chk(0, {tag, " req vs model"}, int'(req), int'(m_state != 0));
        ack = 0;
      end else if (req && ($urandom % 100) < pct) begin
        int rem, el;
        rem = m_end() - m_addr + 1;
        el  = (rem < bw_of(burst_code)) ? rem : bw_of(burst_code);
        chk(int'(req_addr) == m_addr, {tag, " addr"}, int'(req_addr), m_addr);
        chk(int'(req_len) == el, {tag, " len"}, int'(req_len), el);
        ack = 1;
        if (el == rem) begin
          if (m_state == 1) begin
            m_pl = 1;
            if (load_mode == 2'd0) begin m_state = 2; m_pair = 0; m_addr = int'(base0); end
            else m_state = 0;
          end else begin
            if (m_pair == 0) m_e0 = 1; else m_e1 = 1;
            m_pair = dual_en ? 1 - m_pair : 0;
            m_addr = m_pair ? int'(base1) : int'(base0);
          end
        end else begin
          m_addr += el;
        end
      end else begin
        ack = 0;
      end
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    ack = 0; clr_wr = 1; clr_mask = 10'h3FF;
    @(negedge clk);
    clr_wr = 0;
    m_pl = 0; m_e0 = 0; m_e1 = 0;
  endtask

  task automatic check_flags(input string tag);
    chk(stat[6] == m_pl, {tag, " R6 palette done bit6"}, int'(stat[6]), int'(m_pl));
    chk(stat[8] == m_e0, {tag, " R6 eof0 bit8"}, int'(stat[8]), int'(m_e0));
    chk(stat[9] == m_e1, {tag, " R6 eof1 bit9"}, int'(stat[9]), int'(m_e1));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4471));
    rst_n = 0; start = 0; stop = 0; load_mode = 0; burst_code = 0;
    dual_en = 0; pal_8bit = 0; pal_base = 0; base0 = 0; ceil0 = 0;
    base1 = 0; ceil1 = 0; ack = 0; active_disp = 0; fifo_empty = 0;
    sync_err = 0; clr_wr = 0; clr_mask = 0; ie_eof = 0; ie_unf = 0; ie_pl = 0;
    m_state = 0; m_addr = 0; m_pair = 0; m_pl = 0; m_e0 = 0; m_e1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    chk(req == 0, "R12 reset req", int'(req), 0);
    chk(stat == 0, "R12 reset stat", int'(stat), 0);
    chk(irq == 0, "R12 reset irq", int'(irq), 0);

    // R3 shortened final burst: 10 words, burst 8
    load_mode = 2'd2; burst_code = 3'd3; dual_en = 0;
    base0 = 16'd100; ceil0 = 16'd109;
    do_start();
    run(40, 100, "R3 short burst");
    do_stop();
    run(2, 100, "R12 after stop");
    chk(req == 0, "R12 stop drops req", int'(req), 0);
    check_flags("R3");
    clear_all();

    // R4 dual buffer alternation
    load_mode = 2'd2; burst_code = 3'd2; dual_en = 1;
    base0 = 16'd200; ceil0 = 16'd203; base1 = 16'd300; ceil1 = 16'd305;
    do_start();
    run(60, 70, "R4 dual");
    do_stop();
    run(1, 0, "R4 stop");
    check_flags("R4");
    clear_all();

    // R1/R5 palette only, 4-bit palette
    load_mode = 2'd1; burst_code = 3'd4; pal_8bit = 0; pal_base = 16'd40;
    do_start();
    run(10, 100, "R1 palette only");
    chk(req == 0, "R1 palette-only goes idle", int'(req), 0);
    check_flags("R1 pal only");
    clear_all();

    // R1/R5 palette then data, 8-bit palette
    load_mode = 2'd0; burst_code = 3'd4; pal_8bit = 1; pal_base = 16'd1000;
    base0 = 16'd2000; ceil0 = 16'd2020; dual_en = 0;
    do_start();
    run(80, 80, "R5 pal8 then data");
    do_stop();
    run(1, 0, "R1 stop");
    check_flags("R1 pal+data");
    clear_all();

    // R1 reserved mode ignored
    load_mode = 2'd3;
    do_start();
    run(3, 100, "R1 mode3");
    chk(req == 0, "R1 mode 3 ignored", int'(req), 0);

    // R2 illegal burst code gives 1 word
    load_mode = 2'd2; burst_code = 3'd6; base0 = 16'd50; ceil0 = 16'd53;
    do_start();
    @(negedge clk);
    start = 0;
    chk(req_len == 5'd1, "R2 illegal code len", int'(req_len), 1);
    // R11 hold while not acknowledged
    run(4, 0, "R11");
    chk(req == 1 && req_addr == 16'd50, "R11 held addr", int'(req_addr), 50);
    run(20, 60, "R2 single words");

    // R7 underflow during fetching
    @(negedge clk);
    ack = 0; active_disp = 1; fifo_empty = 1;
    @(negedge clk);
    active_disp = 0; fifo_empty = 0;
    chk(stat[5] == 1, "R7 underflow set", int'(stat[5]), 1);
    // R10 enables
    ie_unf = 0;
    #1 chk(irq == 0, "R10 irq masked", int'(irq), 0);
    ie_unf = 1;
    #1 chk(irq == 1, "R10 irq underflow", int'(irq), 1);
    ie_unf = 0;
    do_stop();
    run(1, 0, "R7 stop");
    clear_all();
    m_e0 = 0;
    chk(stat[5] == 0, "R9 underflow cleared", int'(stat[5]), 0);
    // R7 not set while idle
    @(negedge clk);
    active_disp = 1; fifo_empty = 1;
    repeat (2) @(negedge clk);
    active_disp = 0; fifo_empty = 0;
    chk(stat[5] == 0, "R7 idle no underflow", int'(stat[5]), 0);

    // R8 sync lost, R10 bit2 never interrupts
    @(negedge clk);
    sync_err = 1; ie_eof = 1; ie_unf = 1; ie_pl = 1;
    @(negedge clk);
    sync_err = 0;
    chk(stat[2] == 1, "R8 sync lost bit2", int'(stat[2]), 1);
    chk(irq == 0, "R10 bit2 no irq", int'(irq), 0);
    // R9 set wins over clear
    sync_err = 1; clr_wr = 1; clr_mask = 10'h004;
    @(negedge clk);
    sync_err = 0; clr_wr = 0;
    chk(stat[2] == 1, "R9 set wins", int'(stat[2]), 1);
    clr_wr = 1;
    @(negedge clk);
    clr_wr = 0;
    chk(stat[2] == 0, "R9 clear bit2", int'(stat[2]), 0);
    ie_eof = 0; ie_unf = 0; ie_pl = 0;

    // random configurations
    for (int t = 0; t < 8; t++) begin
      int sz0, sz1;
      load_mode  = 2'($urandom % 3);
      burst_code = 3'($urandom % 8);
      dual_en    = 1'($urandom % 2);
      pal_8bit   = 1'($urandom % 2);
      pal_base   = 16'(100 + $urandom % 500);
      sz0 = 1 + $urandom % 40;
      sz1 = 1 + $urandom % 40;
      base0 = 16'(4000 + $urandom % 1000); ceil0 = base0 + 16'(sz0 - 1);
      base1 = 16'(8000 + $urandom % 1000); ceil1 = base1 + 16'(sz1 - 1);
      do_start();
      run(500, 30 + $urandom % 70, "R3 R4 random");
      do_stop();
      run(1, 0, "random stop");
      check_flags("random");
      ie_eof = 1; ie_pl = 1;
      #1 chk(irq == (m_pl | m_e0 | m_e1), "R10 random irq", int'(irq), int'(m_pl | m_e0 | m_e1));
      ie_eof = 0; ie_pl = 0;
      clear_all();
      chk(stat == 0, "R9 clear all", int'(stat), 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule